// File: doc/BRIEF.md
# Idle-Driven Low-Power Mode Sequencer

This block decides when a memory controller drops into one of five low-power modes and when it returns to the active state. The modes are ranked by depth: 1 is power-down, 2 is power-down with the memory clock stopped, 3 is self-refresh, 4 is self-refresh with the memory clock stopped, and 5 is self-refresh with both the memory clock and the controller clock stopped. Each mode has an enable bit and an automatic-entry bit. Software can also ask for entry directly with a manual request. Automatic entry compares four idle-cycle counters against programmable thresholds. Modes 1 and 2 share one counter.

The block reports the current mode as a 3-bit code. It also raises one-cycle entry and exit strobes, which the memory command path turns into real power-down or self-refresh commands. When more than one mode qualifies, the deepest one wins. To move from a shallow mode to a deeper one, the block first returns to active, then waits a fixed gap, then enters the deeper mode.

Top module: `lp_mode_sequencer`

## Requirements
- R1: During and directly after reset, mode_o is 0 and both enter_o and exit_o are low.
- R2: mode_o uses 0 for active and 1 to 5 for the modes in depth order. mode_o changes only together with a one-cycle strobe: enter_o when it leaves 0, and exit_o when it returns to 0.
- R3: mode_en_i and auto_en_i use bit k for mode k+1. An automatic-entry bit whose enable bit is clear has no effect, however long the idle time.
- R4: When several modes qualify at the same clock edge, the deepest qualifying mode is entered.
- R5: Counters are mapped to thresholds as follows: thr_pd_i serves modes 1 and 2, thr_sr_i serves mode 3, thr_ext_i serves mode 4, and thr_int_i serves mode 5. With a mode enabled and auto-entry set, T+1 consecutive idle cycles at threshold T make mode_o show that mode.
- R6: Automatic entry into mode 1 is blocked while mode 2 is enabled. In that case the shared counter leads to mode 2.
- R7: A manual_req_i pulse makes the block enter the deepest enabled mode on the next clock edge, with no idle count needed. The request stays pending until that entry happens or until activity cancels it.
- R8: If a deeper mode qualifies while the block is in a mode, the block exits to 0 on the next edge. If idle continues, it enters the deeper mode exactly GAP_CYCLES+1 edges after the exit (16 by default).
- R9: Activity means idle_i low or wake_i high. Activity in a mode forces mode_o to 0 with exit_o on the next edge. It also clears the idle counters and any pending manual request, and blocks entry on that edge.
- R10: A request for a mode no deeper than the current one leaves the mode unchanged and raises no strobe.
- R11: Every exit, including one caused by wake_i, is followed by at least GAP_CYCLES cycles at mode 0 before the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_i | input | 1 | Controller has no pending work this cycle |
| wake_i | input | 1 | Wake or activity request |
| manual_req_i | input | 1 | Pulse requesting entry into the deepest enabled mode |
| mode_en_i | input | 5 | Per-mode enable, bit k is mode k+1 |
| auto_en_i | input | 5 | Per-mode automatic-entry bit, bit k is mode k+1 |
| thr_pd_i | input | CNT_W | Idle threshold for modes 1 and 2 |
| thr_sr_i | input | CNT_W | Idle threshold for mode 3 |
| thr_ext_i | input | CNT_W | Idle threshold for mode 4 |
| thr_int_i | input | CNT_W | Idle threshold for mode 5 |
| mode_o | output | 3 | Current mode, 0 is active |
| enter_o | output | 1 | One-cycle strobe on entry into a mode |
| exit_o | output | 1 | One-cycle strobe on return to active |

## Verification
Every output is a register updated from the inputs present at one clock edge. An entry or exit caused by a stimulus therefore appears one edge later. An automatic entry appears T+1 edges after idle begins, and a re-entry after an exit appears GAP_CYCLES+1 edges after the exit edge. The bench drives inputs and samples outputs on the falling edge. A cycle-level reference model advances on each rising edge, and each falling-edge sample is compared with the model state from the edge just past. The directed cases count edges from their stimulus and check at exactly those edge counts.

// File: rtl/lp_seq_pkg.sv
// Package: shared constants and helper functions for the low-power sequencer.
// Assumes exactly five modes ranked by depth and four idle counters.
package lp_seq_pkg;

    localparam int NUM_MODES = 5;
    localparam int NUM_CNT   = 4;
    localparam int MODE_W    = 3;

    typedef logic [MODE_W-1:0] lp_mode_t;

    // Maps a zero-based mode index to the idle counter that times it.
    function automatic int cnt_of_mode(input int m);
        return (m < 2) ? 0 : m - 1;
    endfunction

    // Returns the deepest mode code whose bit is set; 0 when none is set.
    function automatic lp_mode_t deepest(input logic [NUM_MODES-1:0] v);
        lp_mode_t res;
        res = '0;
        for (int i = 0; i < NUM_MODES; i++) begin
            if (v[i]) res = lp_mode_t'(i + 1);
        end
        return res;
    endfunction

endpackage

// File: rtl/lp_idle_counter.sv
// Module: saturating counter of consecutive idle cycles with threshold compare.
// Assumes clear_i marks any activity; the count holds at its maximum value.
module lp_idle_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count idle cycles, restart on activity, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Threshold reached once the counted idle cycles reach thr_i.
    always_comb begin
        expired_o = (cnt_q >= thr_i);
    end

endmodule

// File: rtl/lp_mode_select.sv
// Module: works out which modes qualify and returns the deepest of them.
// Assumes expired_i is indexed by counter, mapped to modes via the package.
module lp_mode_select
    import lp_seq_pkg::*;
(
    input  logic [NUM_MODES-1:0] mode_en_i,
    input  logic [NUM_MODES-1:0] auto_en_i,
    input  logic [NUM_CNT-1:0]   expired_i,
    input  logic                 manual_act_i,
    output lp_mode_t             want_o
);

    logic [NUM_MODES-1:0] auto_ok;
    logic [NUM_MODES-1:0] elig;

    // One automatic qualification term per mode, tied to its counter.
    for (genvar g = 0; g < NUM_MODES; g++) begin : g_auto
        localparam int CI = cnt_of_mode(g);
        if (g == 0) begin : g_shared
            // The shallow power-down mode yields the shared counter to mode 2.
            assign auto_ok[g] = mode_en_i[g] & auto_en_i[g] & expired_i[CI]
                                & ~mode_en_i[1];
        end else begin : g_plain
            assign auto_ok[g] = mode_en_i[g] & auto_en_i[g] & expired_i[CI];
        end
    end

    // Merge automatic and manual qualification, then pick the deepest.
    always_comb begin
        elig   = auto_ok | (manual_act_i ? mode_en_i : '0);
        want_o = deepest(elig);
    end

endmodule

// File: rtl/lp_seq_fsm.sv
// Module: holds the current mode, decides entry and exit, times the gap.
// Assumes want_i is the deepest qualifying mode and activity_i wins over all.
module lp_seq_fsm
    import lp_seq_pkg::*;
#(
    parameter int GAP_CYCLES = 15
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     activity_i,
    input  logic     manual_req_i,
    input  logic     any_en_i,
    input  lp_mode_t want_i,
    output lp_mode_t mode_o,
    output logic     enter_o,
    output logic     exit_o,
    output logic     pend_o
);

    localparam int GAP_W = $clog2(GAP_CYCLES + 1);

    lp_mode_t         mode_q;
    logic [GAP_W-1:0] gap_q;
    logic             pend_q;
    logic             enter_q;
    logic             exit_q;
    logic             do_exit;
    logic             do_enter;

    // Decide this edge's transition: activity first, then deepen, then enter.
    always_comb begin
        do_exit  = (mode_q != '0) && (activity_i || (want_i > mode_q));
        do_enter = !activity_i && (mode_q == '0) && (gap_q == '0)
                   && (want_i != '0);
    end

    // Register mode, strobes, gap timer and the pending manual request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            gap_q   <= '0;
            pend_q  <= 1'b0;
            enter_q <= 1'b0;
            exit_q  <= 1'b0;
        end else begin
            enter_q <= do_enter;
            exit_q  <= do_exit;
            if (do_exit) begin
                mode_q <= '0;
                gap_q  <= GAP_W'(GAP_CYCLES);
            end else begin
                if (do_enter) mode_q <= want_i;
                if (gap_q != '0) gap_q <= gap_q - 1'b1;
            end
            if (activity_i || do_enter) begin
                pend_q <= 1'b0;
            end else if (manual_req_i && any_en_i) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign mode_o  = mode_q;
    assign enter_o = enter_q;
    assign exit_o  = exit_q;
    assign pend_o  = pend_q;

endmodule

// File: rtl/lp_mode_sequencer.sv
// Module: top of the low-power sequencer; counters, selector and FSM.
// Assumes thresholds are quasi-static and inputs are synchronous to clk.
module lp_mode_sequencer
    import lp_seq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int GAP_CYCLES = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idle_i,
    input  logic                 wake_i,
    input  logic                 manual_req_i,
    input  logic [NUM_MODES-1:0] mode_en_i,
    input  logic [NUM_MODES-1:0] auto_en_i,
    input  logic [CNT_W-1:0]     thr_pd_i,
    input  logic [CNT_W-1:0]     thr_sr_i,
    input  logic [CNT_W-1:0]     thr_ext_i,
    input  logic [CNT_W-1:0]     thr_int_i,
    output logic [MODE_W-1:0]    mode_o,
    output logic                 enter_o,
    output logic                 exit_o
);

    logic                activity;
    logic [CNT_W-1:0]    thr_arr [NUM_CNT];
    logic [NUM_CNT-1:0]  expired;
    logic                pend;
    lp_mode_t            want;

    // Activity is any non-idle cycle or an explicit wake.
    assign activity = wake_i | ~idle_i;

    assign thr_arr[0] = thr_pd_i;
    assign thr_arr[1] = thr_sr_i;
    assign thr_arr[2] = thr_ext_i;
    assign thr_arr[3] = thr_int_i;

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        lp_idle_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear_i   (activity),
            .thr_i     (thr_arr[c]),
            .expired_o (expired[c])
        );
    end

    lp_mode_select u_sel (
        .mode_en_i    (mode_en_i),
        .auto_en_i    (auto_en_i),
        .expired_i    (expired),
        .manual_act_i (manual_req_i | pend),
        .want_o       (want)
    );

    lp_seq_fsm #(
        .GAP_CYCLES (GAP_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .activity_i   (activity),
        .manual_req_i (manual_req_i),
        .any_en_i     (|mode_en_i),
        .want_i       (want),
        .mode_o       (mode_o),
        .enter_o      (enter_o),
        .exit_o       (exit_o),
        .pend_o       (pend)
    );

endmodule

// File: rtl/lp_mode_sequencer_chk.sv
// Module: property checker bound to the sequencer top.
// Assumes synchronous active-low reset; watches ports only.
module lp_mode_sequencer_chk #(
    parameter int GAP_CYCLES = 15
) (
    input logic       clk,
    input logic       rst_n,
    input logic       idle_i,
    input logic       wake_i,
    input logic [4:0] mode_en_i,
    input logic [2:0] mode_o,
    input logic       enter_o,
    input logic       exit_o
);

    localparam int SW = $clog2(GAP_CYCLES + 2) + 1;

    logic [SW-1:0] since_exit;
    logic [4:0]    en_q;
    logic [2:0]    idx;

    // Count cycles since the last exit strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_exit <= '1;
            en_q       <= '0;
        end else begin
            en_q <= mode_en_i;
            if (exit_o) since_exit <= SW'(1);
            else if (since_exit != '1) since_exit <= since_exit + 1'b1;
        end
    end

    assign idx = mode_o - 3'd1;

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (mode_o == 3'd0 && !enter_o && !exit_o));

    a_r2_mode_range: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o <= 3'd5);

    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({enter_o, exit_o}));

    a_r2_enter_from_active: assert property (@(posedge clk) disable iff (!rst_n)
        enter_o |-> (mode_o != 3'd0 && $past(mode_o) == 3'd0));

    a_r2_exit_to_active: assert property (@(posedge clk) disable iff (!rst_n)
        exit_o |-> (mode_o == 3'd0 && $past(mode_o) != 3'd0));

    a_r2_mode_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!enter_o && !exit_o) |-> $stable(mode_o));

    a_r3_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        enter_o |-> en_q[idx]);

    a_r9_activity_exits: assert property (@(posedge clk) disable iff (!rst_n)
        ((wake_i || !idle_i) && mode_o != 3'd0) |=> (exit_o && mode_o == 3'd0));

    a_r9_activity_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_i || !idle_i) |=> !enter_o);

    a_r11_gap_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
        enter_o |-> (since_exit >= SW'(GAP_CYCLES)));

endmodule

bind lp_mode_sequencer lp_mode_sequencer_chk #(
    .GAP_CYCLES (GAP_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_i    (idle_i),
    .wake_i    (wake_i),
    .mode_en_i (mode_en_i),
    .mode_o    (mode_o),
    .enter_o   (enter_o),
    .exit_o    (exit_o)
);

// File: tb/lp_mode_sequencer_tb.sv
`timescale 1ns/1ps
module lp_mode_sequencer_tb;

    localparam int CNT_W = 16;
    localparam int GAP   = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             idle_i = 1'b0;
    logic             wake_i = 1'b0;
    logic             manual_req_i = 1'b0;
    logic [4:0]       mode_en_i = '0;
    logic [4:0]       auto_en_i = '0;
    logic [CNT_W-1:0] thr_pd_i = '0;
    logic [CNT_W-1:0] thr_sr_i = '0;
    logic [CNT_W-1:0] thr_ext_i = '0;
    logic [CNT_W-1:0] thr_int_i = '0;
    logic [2:0]       mode_o;
    logic             enter_o;
    logic             exit_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    lp_mode_sequencer #(.CNT_W(CNT_W), .GAP_CYCLES(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .wake_i(wake_i),
        .manual_req_i(manual_req_i), .mode_en_i(mode_en_i), .auto_en_i(auto_en_i),
        .thr_pd_i(thr_pd_i), .thr_sr_i(thr_sr_i), .thr_ext_i(thr_ext_i),
        .thr_int_i(thr_int_i), .mode_o(mode_o), .enter_o(enter_o), .exit_o(exit_o)
    );

    // Reference model state, advanced on each rising edge.
    int m_mode, m_gap, m_cnt;
    bit m_pend, m_enter, m_exit;

    function automatic int deepest_of(input bit [4:0] v);
        int r = 0;
        for (int i = 0; i < 5; i++) if (v[i]) r = i + 1;
        return r;
    endfunction

    function automatic int thr_for(input int m);
        case (m)
            0, 1: return int'(thr_pd_i);
            2:    return int'(thr_sr_i);
            3:    return int'(thr_ext_i);
            default: return int'(thr_int_i);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_gap = 0; m_cnt = 0;
            m_pend = 0; m_enter = 0; m_exit = 0;
        end else begin
            bit act, dx, dn;
            bit [4:0] el;
            int want;
            act = wake_i || !idle_i;
            for (int i = 0; i < 5; i++)
                el[i] = mode_en_i[i] && auto_en_i[i] && (m_cnt >= thr_for(i))
                        && !(i == 0 && mode_en_i[1]);
            if (manual_req_i || m_pend) el = el | mode_en_i;
            want = deepest_of(el);
            dx = (m_mode != 0) && (act || want > m_mode);
            dn = !act && m_mode == 0 && m_gap == 0 && want != 0;
            m_gap   = dx ? GAP : (m_gap != 0 ? m_gap - 1 : 0);
            m_pend  = act ? 0 : dn ? 0 : (manual_req_i && |mode_en_i) ? 1 : m_pend;
            m_mode  = dx ? 0 : dn ? want : m_mode;
            m_enter = dn;
            m_exit  = dx;
            m_cnt   = act ? 0 : m_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: rising edge, then compare against the model at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk({mode_o, enter_o, exit_o} == {3'(m_mode), m_enter, m_exit}, "R2 model",
            int'({mode_o, enter_o, exit_o}), int'({3'(m_mode), m_enter, m_exit}));
    endtask

    task automatic quiet(input int n);
        idle_i = 1'b0;
        repeat (n) step();
        idle_i = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mode_o == 0 && !enter_o && !exit_o, "R1", int'(mode_o), 0);
        rst_n = 1'b1;
        step();
        chk(mode_o == 0 && !enter_o && !exit_o, "R1", int'(mode_o), 0);

        // R5: self-refresh auto entry at threshold 5 needs 6 idle edges.
        mode_en_i = 5'b00100; auto_en_i = 5'b00100; thr_sr_i = 16'd5;
        idle_i = 1'b1;
        repeat (5) step();
        chk(mode_o == 0, "R5", int'(mode_o), 0);
        step();
        chk(mode_o == 3 && enter_o, "R5", int'(mode_o), 3);
        step();
        chk(!enter_o && mode_o == 3, "R2", int'(enter_o), 0);

        // R9: wake leaves the mode on the next edge.
        wake_i = 1'b1; step(); wake_i = 1'b0;
        chk(mode_o == 0 && exit_o, "R9", int'(mode_o), 0);
        quiet(20);

        // R3: auto bits without enables do nothing.
        mode_en_i = '0; auto_en_i = 5'b11111;
        thr_pd_i = 0; thr_sr_i = 0; thr_ext_i = 0; thr_int_i = 0;
        repeat (30) step();
        chk(mode_o == 0, "R3", int'(mode_o), 0);
        quiet(20);

        // R6: mode 1 auto blocked while mode 2 enabled; then mode 2 taken.
        mode_en_i = 5'b00011; auto_en_i = 5'b00001; thr_pd_i = 16'd2;
        repeat (20) step();
        chk(mode_o == 0, "R6", int'(mode_o), 0);
        auto_en_i = 5'b00011; step();
        chk(mode_o == 2, "R6", int'(mode_o), 2);
        quiet(20);

        // R4: several qualify together, deepest wins.
        mode_en_i = 5'b10101; auto_en_i = 5'b10101;
        thr_pd_i = 3; thr_sr_i = 3; thr_int_i = 3;
        repeat (4) step();
        chk(mode_o == 5, "R4", int'(mode_o), 5);
        quiet(20);

        // R7: manual request enters the deepest enabled mode next edge.
        auto_en_i = '0; mode_en_i = 5'b01011;
        manual_req_i = 1'b1; step(); manual_req_i = 1'b0;
        chk(mode_o == 4 && enter_o, "R7", int'(mode_o), 4);

        // R8: deeper manual request: exit, gap, re-enter.
        mode_en_i = 5'b11000;
        manual_req_i = 1'b1; step(); manual_req_i = 1'b0;
        chk(mode_o == 0 && exit_o, "R8", int'(mode_o), 0);
        repeat (GAP) step();
        chk(mode_o == 0, "R8", int'(mode_o), 0);
        step();
        chk(mode_o == 5 && enter_o, "R8", int'(mode_o), 5);

        // R10: no deeper request keeps the mode and strobes low.
        mode_en_i = 5'b10001; auto_en_i = 5'b00001; thr_pd_i = 0;
        manual_req_i = 1'b1; step(); manual_req_i = 1'b0;
        repeat (3) step();
        chk(mode_o == 5 && !exit_o && !enter_o, "R10", int'(mode_o), 5);

        // R11: wake exit then an immediate manual request still waits the gap.
        auto_en_i = '0; mode_en_i = 5'b00100;
        wake_i = 1'b1; step(); wake_i = 1'b0;
        manual_req_i = 1'b1; step(); manual_req_i = 1'b0;
        repeat (GAP - 1) step();
        chk(mode_o == 0, "R11", int'(mode_o), 0);
        step();
        chk(mode_o == 3 && enter_o, "R11", int'(mode_o), 3);
        quiet(20);

        // Random phase against the reference model.
        void'($urandom(32'h5EED_1234));
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc % 200 == 0) begin
                thr_pd_i  = CNT_W'($urandom_range(0, 24));
                thr_sr_i  = CNT_W'($urandom_range(0, 32));
                thr_ext_i = CNT_W'($urandom_range(0, 40));
                thr_int_i = CNT_W'($urandom_range(0, 48));
            end
            if (cyc % 60 == 0) begin
                mode_en_i = 5'($urandom);
                auto_en_i = 5'($urandom);
            end
            idle_i       = ($urandom_range(0, 99) < 96);
            wake_i       = ($urandom_range(0, 199) < 2);
            manual_req_i = ($urandom_range(0, 99) < 2);
            step();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule